// File: doc/BRIEF.md
# Threshold Interrupt Persistence Filter

This block turns a stream of 16-bit conversion results into a level-style interrupt. It serves two measurement channels, one for ambient light and one for proximity. Each channel has its own low and high thresholds, a 4-bit persistence code, an interrupt enable and a clear pulse. A new sample arrives with a one-cycle done strobe. The channel compares that sample against its two thresholds and keeps a count of consecutive out-of-range results.

A channel's flag is set when that count reaches the number of samples its persistence code calls for, and only if the channel's enable is high. The flag then stays set until a clear pulse arrives. A code of 0 sets the flag on every completed conversion. The two channels decode the code differently. The ambient channel uses a stepped table that grows by fives. The proximity channel takes the code directly as a sample count.

The two flags are ORed and inverted onto a single active-low interrupt output, which suits an open-drain pad. Register storage and the host bus sit outside this block. They supply the thresholds, codes, enables and clear pulses as plain inputs.

Top module: `thr_irq_pair`

## Requirements
- R1: A sample is out of range when it is strictly below the low threshold or strictly above the high threshold. A sample equal to either threshold is in range.
- R2: With a persistence code of 0 and the enable set, every done strobe sets the flag, whatever the sample value.
- R3: On the ambient channel, codes 1, 2 and 3 need 1, 2 and 3 consecutive out-of-range samples. Code 4 needs 5. A code c from 5 to 15 needs 5*(c-3), so code 15 needs 60.
- R4: On the proximity channel, a code c from 1 to 15 needs exactly c consecutive out-of-range samples.
- R5: A set flag stays set through any later samples and idle cycles until a clear pulse. A clear pulse with no triggering event clears the flag at the next clock edge.
- R6: While a channel's enable is low, its flag does not become set.
- R7: Any in-range sample taken on a done strobe resets that channel's consecutive count to zero.
- R8: If a clear pulse and a triggering event arrive in the same cycle, the flag is set.
- R9: The output irq_n is low when either flag is set and high when both are clear. After reset, both flags are clear and irq_n is high.
- R10: A sample is taken only on a cycle with the done strobe high. Data on the sample input at other times has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| amb_done | input | 1 | Ambient conversion complete strobe |
| amb_sample | input | 16 | Ambient conversion result |
| amb_lo | input | 16 | Ambient low threshold |
| amb_hi | input | 16 | Ambient high threshold |
| amb_pers | input | 4 | Ambient persistence code (stepped table) |
| amb_ien | input | 1 | Ambient interrupt enable |
| amb_clr | input | 1 | Ambient flag clear pulse |
| prx_done | input | 1 | Proximity conversion complete strobe |
| prx_sample | input | 16 | Proximity conversion result |
| prx_lo | input | 16 | Proximity low threshold |
| prx_hi | input | 16 | Proximity high threshold |
| prx_pers | input | 4 | Proximity persistence code (direct count) |
| prx_ien | input | 1 | Proximity interrupt enable |
| prx_clr | input | 1 | Proximity flag clear pulse |
| amb_flag | output | 1 | Ambient sticky interrupt flag |
| prx_flag | output | 1 | Proximity sticky interrupt flag |
| irq_n | output | 1 | Active-low combined interrupt |

## Verification
The bench drives samples exactly at each threshold, where a design using the wrong comparison would fire one sample early. It uses code 4 on both channels, which needs 5 samples on the ambient channel and 4 on the proximity channel, so a swapped decode fires on the wrong sample. It also runs the longest window of 60 samples. An in-range sample inserted into a run of out-of-range samples catches a counter that does not reset, because the flag would then rise one sample too early. A clear arriving in the same cycle as a code-0 strobe catches a design that lets the clear win, and a sample held on the input without a strobe catches a design that samples continuously.

// File: rtl/thr_irq_pkg.sv
package thr_irq_pkg;
   typedef enum logic {PERS_STEPPED = 1'b0, PERS_LINEAR = 1'b1} pers_map_e;

   function automatic int max_need(input pers_map_e m, input int pw);
      int top_code;
      top_code = (1 << pw) - 1;
      if (m == PERS_STEPPED) return (top_code - 3) * 5;
      return top_code;
   endfunction
endpackage

// File: rtl/persist_decode.sv
module persist_decode
   import thr_irq_pkg::*;
#(
   parameter pers_map_e MAP = PERS_STEPPED,
   parameter int        PW  = 4,
   parameter int        CW  = 6
) (
   input  logic [PW-1:0] code,
   output logic [CW-1:0] need
);
   localparam int MAXN = max_need(MAP, PW);

   if (MAP == PERS_STEPPED && PW < 3) begin : g_bad_pw
      $error("persist_decode: stepped map needs PW >= 3");
   end
   if ((1 << CW) <= MAXN) begin : g_bad_cw
      $error("persist_decode: CW too narrow for largest window");
   end

   if (MAP == PERS_STEPPED) begin : g_stepped
      always_comb begin
         int c;
         c = int'(code);
         if (c <= 3)      need = CW'(c);
         else if (c == 4) need = CW'(5);
         else             need = CW'((c - 3) * 5);
      end
   end else begin : g_linear
      always_comb need = CW'(code);
   end

   always_comb begin
      if (code != '0) AST_NEED_NONZERO: assert (need != '0); // R3
   end
endmodule

// File: rtl/range_check.sv
module range_check #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] sample,
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] hi,
   output logic          outside
);
   always_comb outside = (sample < lo) || (sample > hi);
endmodule

// File: rtl/chan_filter.sv
module chan_filter
   import thr_irq_pkg::*;
#(
   parameter pers_map_e MAP = PERS_STEPPED,
   parameter int        DW  = 16,
   parameter int        PW  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done,
   input  logic [DW-1:0] sample,
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] hi,
   input  logic [PW-1:0] pers,
   input  logic          ien,
   input  logic          clr,
   output logic          flag
);
   localparam int MAXN = max_need(MAP, PW);
   localparam int CW   = $clog2(MAXN + 1);

   logic          outside;
   logic [CW-1:0] need;
   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_inc;
   logic          hit;

   range_check #(.DW(DW)) u_cmp (
      .sample (sample),
      .lo     (lo),
      .hi     (hi),
      .outside(outside)
   );

   persist_decode #(.MAP(MAP), .PW(PW), .CW(CW)) u_dec (
      .code(pers),
      .need(need)
   );

   always_comb begin
      cnt_inc = (cnt == '1) ? cnt : cnt + 1'b1;
      hit     = done && ((pers == '0) || (outside && (cnt_inc >= need)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (done) cnt <= outside ? cnt_inc : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag <= 1'b0;
      else if (hit && ien)  flag <= 1'b1;
      else if (clr)         flag <= 1'b0;
   end

   AST_INRANGE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !outside) |=> (cnt == '0)); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag); // R5
   AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(ien && done)); // R6
   AST_ZERO_CODE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ien && pers == '0) |=> flag); // R2
   AST_IDLE_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(cnt)); // R10
endmodule

// File: rtl/thr_irq_pair.sv
module thr_irq_pair
   import thr_irq_pkg::*;
#(
   parameter int DW = 16,
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          amb_done,
   input  logic [DW-1:0] amb_sample,
   input  logic [DW-1:0] amb_lo,
   input  logic [DW-1:0] amb_hi,
   input  logic [PW-1:0] amb_pers,
   input  logic          amb_ien,
   input  logic          amb_clr,
   input  logic          prx_done,
   input  logic [DW-1:0] prx_sample,
   input  logic [DW-1:0] prx_lo,
   input  logic [DW-1:0] prx_hi,
   input  logic [PW-1:0] prx_pers,
   input  logic          prx_ien,
   input  logic          prx_clr,
   output logic          amb_flag,
   output logic          prx_flag,
   output logic          irq_n
);
   if (DW < 1) begin : g_bad_dw
      $error("thr_irq_pair: DW must be positive");
   end

   chan_filter #(.MAP(PERS_STEPPED), .DW(DW), .PW(PW)) u_amb (
      .clk(clk), .rst_n(rst_n), .done(amb_done), .sample(amb_sample),
      .lo(amb_lo), .hi(amb_hi), .pers(amb_pers), .ien(amb_ien),
      .clr(amb_clr), .flag(amb_flag)
   );

   chan_filter #(.MAP(PERS_LINEAR), .DW(DW), .PW(PW)) u_prx (
      .clk(clk), .rst_n(rst_n), .done(prx_done), .sample(prx_sample),
      .lo(prx_lo), .hi(prx_hi), .pers(prx_pers), .ien(prx_ien),
      .clr(prx_clr), .flag(prx_flag)
   );

   always_comb irq_n = ~(amb_flag | prx_flag);

   AST_PIN_RISE_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n) |-> $past(amb_clr || prx_clr)); // R9
endmodule

// File: tb/tb_thr_irq_pair.sv
module tb_thr_irq_pair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        amb_done = 0, amb_ien = 0, amb_clr = 0;
   logic [15:0] amb_sample = 0, amb_lo = 16'd100, amb_hi = 16'd200;
   logic [3:0]  amb_pers = 0;
   logic        prx_done = 0, prx_ien = 0, prx_clr = 0;
   logic [15:0] prx_sample = 0, prx_lo = 16'd100, prx_hi = 16'd200;
   logic [3:0]  prx_pers = 0;
   logic        amb_flag, prx_flag, irq_n;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   thr_irq_pair dut (
      .clk(clk), .rst_n(rst_n),
      .amb_done(amb_done), .amb_sample(amb_sample), .amb_lo(amb_lo), .amb_hi(amb_hi),
      .amb_pers(amb_pers), .amb_ien(amb_ien), .amb_clr(amb_clr),
      .prx_done(prx_done), .prx_sample(prx_sample), .prx_lo(prx_lo), .prx_hi(prx_hi),
      .prx_pers(prx_pers), .prx_ien(prx_ien), .prx_clr(prx_clr),
      .amb_flag(amb_flag), .prx_flag(prx_flag), .irq_n(irq_n)
   );

   // {ch, clr_first, ien, pers[3:0], sample[15:0], expected_flag}; ch 0 = ambient
   localparam int NV = 27;
   localparam logic [23:0] VEC [NV] = '{
      {1'b0,1'b1,1'b1,4'd1,16'd150,1'b0},
      {1'b0,1'b0,1'b1,4'd1,16'd100,1'b0},  // R1 equal low
      {1'b0,1'b0,1'b1,4'd1,16'd200,1'b0},  // R1 equal high
      {1'b0,1'b0,1'b1,4'd1,16'd99, 1'b1},  // R1 below low
      {1'b0,1'b1,1'b1,4'd2,16'd150,1'b0},
      {1'b0,1'b0,1'b1,4'd2,16'd201,1'b0},  // R3 code 2
      {1'b0,1'b0,1'b1,4'd2,16'd201,1'b1},
      {1'b0,1'b1,1'b1,4'd4,16'd150,1'b0},
      {1'b0,1'b0,1'b1,4'd4,16'd0,  1'b0},  // R3 code 4 = 5 samples
      {1'b0,1'b0,1'b1,4'd4,16'd0,  1'b0},
      {1'b0,1'b0,1'b1,4'd4,16'd0,  1'b0},
      {1'b0,1'b0,1'b1,4'd4,16'd0,  1'b0},
      {1'b0,1'b0,1'b1,4'd4,16'd0,  1'b1},
      {1'b0,1'b1,1'b1,4'd3,16'd150,1'b0},
      {1'b0,1'b0,1'b1,4'd3,16'd300,1'b0},  // R7 run broken
      {1'b0,1'b0,1'b1,4'd3,16'd150,1'b0},
      {1'b0,1'b0,1'b1,4'd3,16'd300,1'b0},
      {1'b0,1'b0,1'b1,4'd3,16'd300,1'b0},
      {1'b0,1'b0,1'b1,4'd3,16'd300,1'b1},
      {1'b0,1'b1,1'b1,4'd0,16'd150,1'b1},  // R2 code 0 in range
      {1'b1,1'b1,1'b1,4'd4,16'd150,1'b0},
      {1'b1,1'b0,1'b1,4'd4,16'd0,  1'b0},  // R4 code 4 = 4 samples
      {1'b1,1'b0,1'b1,4'd4,16'd0,  1'b0},
      {1'b1,1'b0,1'b1,4'd4,16'd0,  1'b0},
      {1'b1,1'b0,1'b1,4'd4,16'd0,  1'b1},
      {1'b1,1'b1,1'b0,4'd0,16'd150,1'b0},  // R6 disabled code 0
      {1'b1,1'b0,1'b0,4'd1,16'd0,  1'b0}   // R6 disabled out of range
   };

   task automatic check(input logic got, input logic exp, input string tag);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic setup(input bit ch, input logic en, input logic [3:0] p);
      if (ch) begin prx_ien = en; prx_pers = p; end
      else    begin amb_ien = en; amb_pers = p; end
   endtask

   task automatic clear_ch(input bit ch);
      @(negedge clk);
      if (ch) prx_clr = 1'b1; else amb_clr = 1'b1;
      @(negedge clk);
      prx_clr = 1'b0; amb_clr = 1'b0;
   endtask

   // drive one strobe during the next cycle; returns at the negedge after it
   task automatic strobe(input bit ch, input logic [15:0] s);
      if (ch) begin prx_done = 1'b1; prx_sample = s; end
      else    begin amb_done = 1'b1; amb_sample = s; end
      @(negedge clk);
      prx_done = 1'b0; amb_done = 1'b0;
   endtask

   function automatic logic flag_of(input bit ch);
      return ch ? prx_flag : amb_flag;
   endfunction

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(amb_flag, 1'b0, "R9 reset ambient flag");
      check(prx_flag, 1'b0, "R9 reset proximity flag");
      check(irq_n, 1'b1, "R9 reset irq_n high");
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         bit ch;
         ch = VEC[i][23];
         setup(ch, VEC[i][21], VEC[i][20:17]);
         if (VEC[i][22]) clear_ch(ch);
         strobe(ch, VEC[i][16:1]);
         check(flag_of(ch), VEC[i][0], $sformatf("vector %0d (R1..R7)", i));
      end

      // R9: ambient flag still set from vector 19, proximity clear
      check(irq_n, 1'b0, "R9 irq_n low with one flag");
      clear_ch(0);
      check(irq_n, 1'b1, "R9 irq_n high with both clear");

      // R3: code 15 needs 60 samples on ambient
      setup(0, 1'b1, 4'd15);
      strobe(0, 16'd150);
      for (int k = 0; k < 59; k++) strobe(0, 16'd5000);
      check(amb_flag, 1'b0, "R3 code 15 after 59");
      strobe(0, 16'd5000);
      check(amb_flag, 1'b1, "R3 code 15 after 60");

      // R5: sticky through in-range samples and idle cycles
      strobe(0, 16'd150);
      repeat (5) @(negedge clk);
      check(amb_flag, 1'b1, "R5 flag held");
      clear_ch(0);
      check(amb_flag, 1'b0, "R5 clear drops flag");

      // R4: code 15 needs 15 samples on proximity
      clear_ch(1);
      setup(1, 1'b1, 4'd15);
      strobe(1, 16'd150);
      for (int k = 0; k < 14; k++) strobe(1, 16'd50);
      check(prx_flag, 1'b0, "R4 code 15 after 14");
      strobe(1, 16'd50);
      check(prx_flag, 1'b1, "R4 code 15 after 15");
      check(irq_n, 1'b0, "R9 irq_n low from proximity");

      // R8: clear and trigger in the same cycle
      setup(0, 1'b1, 4'd0);
      amb_clr = 1'b1;
      strobe(0, 16'd150);
      amb_clr = 1'b0;
      check(amb_flag, 1'b1, "R8 set wins over clear");

      // R10: out-of-range data without strobe is ignored
      clear_ch(1);
      setup(1, 1'b1, 4'd1);
      strobe(1, 16'd150);
      prx_sample = 16'd9;
      repeat (6) @(negedge clk);
      check(prx_flag, 1'b0, "R10 no strobe no sample");
      strobe(1, 16'd150);
      check(prx_flag, 1'b0, "R10 count untouched by idle data");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule